// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet Buffer

This block stores outgoing or incoming endpoint data as whole packets. It keeps one packet, or two when double buffering is switched on. A load side writes bytes one at a time and closes each packet with a done strobe. The load side may be the CPU or a DMA engine. An unload side, normally the serial transmitter or the receive path, drains the oldest packet byte by byte. It sees the length of that packet and a marker on its last byte.

Occupancy is counted in packets, not in bytes. The block requests DMA service whenever another packet fits. A flush command drops exactly one packet, so a full double buffer needs two flushes. Packets longer than the programmed maximum size are cut to that size, and a sticky overrun flag is raised. A one-cycle interrupt pulse reports that a packet has been unloaded. When the DMA mode bit is set, only errors raise that pulse.

Top module: `ep_pkt_fifo`

## Requirements
- R1: After reset the buffer holds no packet, `pkt_rdy_o`, `irq_o` and `ovr_err_o` are 0, and `dma_req_o` equals `dma_en_i`.
- R2: With `dbl_buf_i`=0 at most one complete packet is held. Any `wr_en_i` or `wr_done_i` while one packet is held is ignored.
- R3: With `dbl_buf_i`=1 at most two complete packets are held. A load attempted while two are held is ignored.
- R4: `dma_req_o` is 1 exactly when `dma_en_i` is 1 and the held packet count is below the limit (1 or 2).
- R5: Packets leave in load order with their bytes in load order. `rd_cnt_o` shows the byte length of the oldest packet, and `rd_data_o` shows its current byte.
- R6: `pkt_rdy_o` stays 1 while at least one complete packet is held. It falls only when the last held packet is unloaded or flushed.
- R7: Each `flush_i` pulse drops the oldest held packet. It takes priority over `rd_en_i` in the same cycle. The next packet is then read from its first byte. A flush with nothing held has no effect.
- R8: Bytes beyond min(`max_pkt_i`, MAX_BYTES) in one packet are discarded, and the stored length equals that limit. `ovr_err_o` then goes to 1 and stays there until `err_clr_i`.
- R9: With `dma_mode_i`=0, `irq_o` pulses for one cycle in the cycle after the last byte of a packet is unloaded. With `dma_mode_i`=1, no pulse is raised for completion.
- R10: `xfer_err_i`, or the setting of `ovr_err_o`, raises `irq_o` in the following cycle whatever the value of `dma_mode_i`.
- R11: `rd_last_o` is 1 exactly while the current unload byte is the last byte of the oldest packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_buf_i | input | 1 | Double buffering enable (limit 2 packets, else 1) |
| dma_en_i | input | 1 | DMA service enabled for this endpoint |
| dma_mode_i | input | 1 | Suppress completion interrupts |
| max_pkt_i | input | CntW | Maximum packet size in bytes |
| wr_en_i | input | 1 | Load one byte |
| wr_data_i | input | DATA_W | Load byte |
| wr_done_i | input | 1 | Close current packet (includes a same-cycle byte) |
| rd_en_i | input | 1 | Unload current byte |
| flush_i | input | 1 | Drop oldest packet |
| xfer_err_i | input | 1 | Transfer error event from the link side |
| err_clr_i | input | 1 | Clear overrun flag |
| rd_data_o | output | DATA_W | Current unload byte |
| rd_last_o | output | 1 | Current byte is last of packet |
| rd_cnt_o | output | CntW | Length of oldest packet, 0 if none |
| pkt_cnt_o | output | 2 | Complete packets held |
| pkt_rdy_o | output | 1 | At least one packet held |
| dma_req_o | output | 1 | Another packet can be accepted |
| irq_o | output | 1 | Endpoint interrupt pulse |
| ovr_err_o | output | 1 | Sticky oversize error |

## Verification
The bench builds the block with MAX_BYTES=8 and DATA_W=8. This keeps every slot a handful of bytes long, so oversize truncation is reached with a seven-byte packet against a limit of five. Both buffering limits and their full, flush and empty transitions are driven in short directed scenarios. The interrupt is checked under both settings of the DMA mode bit, with and without error events.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  typedef logic [1:0] pcnt_t;

  function automatic pcnt_t pkt_limit(input logic dbl);
    return dbl ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/ep_slot_mem.sv
module ep_slot_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int NSLOT  = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SW-1:0]     wslot_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SW-1:0]     rslot_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_rd [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DATA_W-1:0] row_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wslot_i == SW'(s)) row_q[waddr_i] <= wdata_i;
    end
    assign slot_rd[s] = row_q[raddr_i];
  end

  assign rdata_o = slot_rd[rslot_i];
endmodule

// File: rtl/ep_pkt_ctrl.sv
module ep_pkt_ctrl
  import ep_fifo_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  localparam int AW   = $clog2(MAX_BYTES),
  localparam int CntW = $clog2(MAX_BYTES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dbl_buf_i,
  input  logic [CntW-1:0] max_pkt_i,
  input  logic            wr_en_i,
  input  logic            wr_done_i,
  input  logic            rd_en_i,
  input  logic            flush_i,
  input  logic            err_clr_i,
  output logic            mem_we_o,
  output logic            mem_wslot_o,
  output logic [AW-1:0]   mem_waddr_o,
  output logic            mem_rslot_o,
  output logic [AW-1:0]   mem_raddr_o,
  output pcnt_t           pkt_cnt_o,
  output logic            has_space_o,
  output logic [CntW-1:0] rd_cnt_o,
  output logic            rd_last_o,
  output logic            done_o,
  output logic            ovr_err_o,
  output logic            ovr_set_o
);
  pcnt_t           cnt_q, cnt_n;
  logic            wslot_q, rslot_q;
  logic [CntW-1:0] wptr_q, rptr_q;
  logic [CntW-1:0] len_q [2];
  logic            ovr_q;
  logic [CntW-1:0] max_eff;
  logic            accept, store, ovr_evt, push, pop, step, is_last, held;
  logic [CntW:0]   rnext;

  assign max_eff  = (max_pkt_i > CntW'(MAX_BYTES)) ? CntW'(MAX_BYTES) : max_pkt_i;
  assign has_space_o = cnt_q < pkt_limit(dbl_buf_i);
  assign held     = cnt_q != 2'd0;
  assign accept   = wr_en_i && has_space_o;
  assign store    = accept && (wptr_q < max_eff);
  assign ovr_evt  = accept && !store;
  assign push     = wr_done_i && has_space_o;

  assign rnext    = {1'b0, rptr_q} + 1'b1;
  assign is_last  = rnext >= {1'b0, len_q[rslot_q]};
  // flush wins over unload in the same cycle
  assign done_o   = held && rd_en_i && !flush_i && is_last;
  assign step     = held && rd_en_i && !flush_i && !is_last;
  assign pop      = (held && flush_i) || done_o;

  always_comb begin
    cnt_n = cnt_q;
    if (push && !pop)      cnt_n = cnt_q + 2'd1;
    else if (!push && pop) cnt_n = cnt_q - 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wslot_q  <= 1'b0;
      rslot_q  <= 1'b0;
      wptr_q   <= '0;
      rptr_q   <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      ovr_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      if (push) begin
        len_q[wslot_q] <= wptr_q + CntW'(store);
        wslot_q        <= ~wslot_q;
        wptr_q         <= '0;
      end else if (store) begin
        wptr_q <= wptr_q + 1'b1;
      end
      if (pop) begin
        rslot_q <= ~rslot_q;
        rptr_q  <= '0;
      end else if (step) begin
        rptr_q <= rnext[CntW-1:0];
      end
      if (ovr_evt)        ovr_q <= 1'b1;
      else if (err_clr_i) ovr_q <= 1'b0;
    end
  end

  assign mem_we_o    = store;
  assign mem_wslot_o = wslot_q;
  assign mem_waddr_o = wptr_q[AW-1:0];
  assign mem_rslot_o = rslot_q;
  assign mem_raddr_o = rptr_q[AW-1:0];
  assign pkt_cnt_o   = cnt_q;
  assign rd_cnt_o    = held ? len_q[rslot_q] : '0;
  assign rd_last_o   = held && is_last;
  assign ovr_err_o   = ovr_q;
  assign ovr_set_o   = ovr_evt && !ovr_q;
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_mode_i,
  input  logic done_i,
  input  logic xfer_err_i,
  input  logic ovr_set_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (done_i && !dma_mode_i) || xfer_err_i || ovr_set_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ep_pkt_fifo.sv
module ep_pkt_fifo
  import ep_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 64,
  localparam int AW   = $clog2(MAX_BYTES),
  localparam int CntW = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbl_buf_i,
  input  logic              dma_en_i,
  input  logic              dma_mode_i,
  input  logic [CntW-1:0]   max_pkt_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_done_i,
  input  logic              rd_en_i,
  input  logic              flush_i,
  input  logic              xfer_err_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic [CntW-1:0]   rd_cnt_o,
  output logic [1:0]        pkt_cnt_o,
  output logic              pkt_rdy_o,
  output logic              dma_req_o,
  output logic              irq_o,
  output logic              ovr_err_o
);
  logic          mem_we, mem_wslot, mem_rslot, has_space, done, ovr_set;
  logic [AW-1:0] mem_waddr, mem_raddr;
  pcnt_t         cnt;

  ep_pkt_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .dbl_buf_i, .max_pkt_i, .wr_en_i, .wr_done_i,
    .rd_en_i, .flush_i, .err_clr_i,
    .mem_we_o(mem_we), .mem_wslot_o(mem_wslot), .mem_waddr_o(mem_waddr),
    .mem_rslot_o(mem_rslot), .mem_raddr_o(mem_raddr),
    .pkt_cnt_o(cnt), .has_space_o(has_space), .rd_cnt_o, .rd_last_o,
    .done_o(done), .ovr_err_o, .ovr_set_o(ovr_set)
  );

  ep_slot_mem #(.DATA_W(DATA_W), .DEPTH(MAX_BYTES), .NSLOT(2)) u_mem (
    .clk_i, .we_i(mem_we), .wslot_i(mem_wslot), .waddr_i(mem_waddr),
    .wdata_i(wr_data_i), .rslot_i(mem_rslot), .raddr_i(mem_raddr),
    .rdata_o(rd_data_o)
  );

  ep_irq_gen u_irq (
    .clk_i, .rst_ni, .dma_mode_i, .done_i(done), .xfer_err_i,
    .ovr_set_i(ovr_set), .irq_o
  );

  assign pkt_cnt_o = cnt;
  assign pkt_rdy_o = cnt != 2'd0;
  assign dma_req_o = dma_en_i && has_space;
endmodule

// File: rtl/ep_pkt_fifo_chk.sv
module ep_pkt_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dbl_buf_i,
  input logic       dma_en_i,
  input logic       dma_mode_i,
  input logic       flush_i,
  input logic       wr_done_i,
  input logic       xfer_err_i,
  input logic       err_clr_i,
  input logic [1:0] pkt_cnt_o,
  input logic       pkt_rdy_o,
  input logic       dma_req_o,
  input logic       irq_o,
  input logic       ovr_err_o
);
  // R2 R3
  cnt_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_cnt_o <= (dbl_buf_i ? 2'd2 : 2'd1));
  // R4
  dma_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> dma_en_i);
  // R6
  rdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pkt_rdy_o) |-> $past(pkt_cnt_o) == 2'd1);
  // R7
  flush_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && pkt_cnt_o == 2'd1 && !wr_done_i) |=> !pkt_rdy_o);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_err_o) |-> $past(err_clr_i));
  // R9
  dma_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(dma_mode_i)) |-> ($past(xfer_err_i) || $rose(ovr_err_o)));
  // R10
  err_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_i |=> irq_o);
endmodule

bind ep_pkt_fifo ep_pkt_fifo_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dbl_buf_i(dbl_buf_i), .dma_en_i(dma_en_i),
  .dma_mode_i(dma_mode_i), .flush_i(flush_i), .wr_done_i(wr_done_i),
  .xfer_err_i(xfer_err_i), .err_clr_i(err_clr_i), .pkt_cnt_o(pkt_cnt_o),
  .pkt_rdy_o(pkt_rdy_o), .dma_req_o(dma_req_o), .irq_o(irq_o),
  .ovr_err_o(ovr_err_o)
);

// File: tb/ep_pkt_fifo_bench.sv
module ep_pkt_fifo_bench;
  localparam int DW = 8;
  localparam int MB = 8;
  localparam int CW = $clog2(MB + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic dbl_buf_i = 0, dma_en_i = 0, dma_mode_i = 0;
  logic [CW-1:0] max_pkt_i = CW'(MB);
  logic wr_en_i = 0, wr_done_i = 0, rd_en_i = 0, flush_i = 0;
  logic xfer_err_i = 0, err_clr_i = 0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic rd_last_o, pkt_rdy_o, dma_req_o, irq_o, ovr_err_o;
  logic [CW-1:0] rd_cnt_o;
  logic [1:0] pkt_cnt_o;

  int nvec = 0, nfail = 0, nirq = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;
  always @(negedge clk_i) if (rst_ni && irq_o) nirq++;

  ep_pkt_fifo #(.DATA_W(DW), .MAX_BYTES(MB)) u_ep_pkt_fifo (.*);

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk_i); #1;
  endtask

  task automatic write_pkt(int n, int seed);
    if (n == 0) begin
      wr_done_i = 1; step; wr_done_i = 0;
    end
    for (int i = 0; i < n; i++) begin
      wr_en_i = 1; wr_data_i = DW'(seed + i); wr_done_i = (i == n - 1);
      step;
    end
    wr_en_i = 0; wr_done_i = 0;
  endtask

  task automatic read_pkt(int n, int seed);
    for (int i = 0; i < n; i++) begin
      chk("R5 rd_cnt", int'(rd_cnt_o), n);
      chk("R5 rd_data", int'(rd_data_o), (seed + i) & 8'hff);
      chk("R11 rd_last", int'(rd_last_o), int'(i == n - 1));
      rd_en_i = 1; step; rd_en_i = 0;
    end
  endtask

  task automatic do_reset;
    rst_ni = 0; step; rst_ni = 1; step;
  endtask

  task automatic t_reset;
    dma_en_i = 1; do_reset;
    chk("R1 cnt", int'(pkt_cnt_o), 0);
    chk("R1 rdy", int'(pkt_rdy_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 ovr", int'(ovr_err_o), 0);
    chk("R1 dma_req", int'(dma_req_o), 1);
  endtask

  task automatic t_single;
    int base;
    dbl_buf_i = 0; dma_en_i = 1; dma_mode_i = 0; do_reset;
    write_pkt(3, 8'h10);
    chk("R2 cnt one", int'(pkt_cnt_o), 1);
    chk("R4 dma_req full", int'(dma_req_o), 0);
    write_pkt(2, 8'h20);
    chk("R2 ignored load", int'(pkt_cnt_o), 1);
    base = nirq;
    read_pkt(3, 8'h10);
    chk("R6 empty rdy", int'(pkt_rdy_o), 0);
    chk("R9 irq pulse", int'(irq_o), 1);
    step;
    chk("R9 irq one cycle", int'(irq_o), 0);
    chk("R9 irq count", nirq - base, 1);
    chk("R4 dma_req space", int'(dma_req_o), 1);
    write_pkt(2, 8'h30);
    read_pkt(2, 8'h30);
    dma_en_i = 0; step;
    chk("R4 dma_req disabled", int'(dma_req_o), 0);
  endtask

  task automatic t_double;
    dbl_buf_i = 1; dma_en_i = 1; do_reset;
    write_pkt(3, 8'h40);
    chk("R4 dma_req one of two", int'(dma_req_o), 1);
    write_pkt(4, 8'h50);
    chk("R3 cnt two", int'(pkt_cnt_o), 2);
    chk("R4 dma_req two", int'(dma_req_o), 0);
    write_pkt(1, 8'h60);
    chk("R3 ignored third", int'(pkt_cnt_o), 2);
    read_pkt(3, 8'h40);
    chk("R6 rdy after first", int'(pkt_rdy_o), 1);
    read_pkt(4, 8'h50);
    chk("R6 rdy after last", int'(pkt_rdy_o), 0);
    chk("R3 drained", int'(pkt_cnt_o), 0);
  endtask

  task automatic t_flush;
    dbl_buf_i = 1; do_reset;
    write_pkt(2, 8'h70);
    write_pkt(5, 8'h80);
    flush_i = 1; step; flush_i = 0;
    chk("R7 first flush cnt", int'(pkt_cnt_o), 1);
    chk("R7 head length", int'(rd_cnt_o), 5);
    chk("R6 rdy kept", int'(pkt_rdy_o), 1);
    flush_i = 1; step; flush_i = 0;
    chk("R7 second flush cnt", int'(pkt_cnt_o), 0);
    flush_i = 1; step; flush_i = 0;
    chk("R7 flush empty", int'(pkt_cnt_o), 0);
    write_pkt(3, 8'h90);
    rd_en_i = 1; step; rd_en_i = 0;
    flush_i = 1; rd_en_i = 1; step; flush_i = 0; rd_en_i = 0;
    chk("R7 flush over read", int'(pkt_cnt_o), 0);
    write_pkt(2, 8'hA0);
    read_pkt(2, 8'hA0);
  endtask

  task automatic t_oversize;
    int base;
    dbl_buf_i = 0; dma_mode_i = 0; do_reset;
    max_pkt_i = 5;
    base = nirq;
    write_pkt(7, 8'hB0);
    step;
    chk("R8 truncated length", int'(rd_cnt_o), 5);
    chk("R8 ovr set", int'(ovr_err_o), 1);
    chk("R10 ovr irq", nirq - base, 1);
    read_pkt(5, 8'hB0);
    step;
    chk("R8 ovr sticky", int'(ovr_err_o), 1);
    err_clr_i = 1; step; err_clr_i = 0;
    chk("R8 ovr cleared", int'(ovr_err_o), 0);
    max_pkt_i = CW'(MB);
  endtask

  task automatic t_dma_mode;
    int base;
    dbl_buf_i = 0; dma_mode_i = 1; do_reset;
    base = nirq;
    write_pkt(2, 8'hC0);
    read_pkt(2, 8'hC0);
    step;
    chk("R9 no completion irq", nirq - base, 0);
    xfer_err_i = 1; step; xfer_err_i = 0;
    chk("R10 err irq dma mode", int'(irq_o), 1);
    step;
    chk("R10 err irq count", nirq - base, 1);
    dma_mode_i = 0;
    xfer_err_i = 1; step; xfer_err_i = 0;
    chk("R10 err irq normal", int'(irq_o), 1);
  endtask

  initial begin
    t_reset;
    t_single;
    t_double;
    t_flush;
    t_oversize;
    t_dma_mode;
    step;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule